// File: doc/BRIEF.md
# Low-Power Clock Mode Controller

This block decides which clock domains of a small microcontroller run and moves the device between normal operation and two standby levels. It produces enables for five domains: the fast oscillator, the slow oscillator, the CPU clock, the peripheral bus clock, and the clock of the slow-clock peripherals such as the periodic timer and the watchdog. It also produces a divider select for the CPU clock. A deep-sleep request turns off everything that can be stopped. A halt request stops only the CPU and keeps the other domains as configured. Configuration inputs are captured when the device enters standby.

Wakeup interrupts come in four classes. A class is accepted only when the domain that produces it is still clocked, and the controller ignores every other interrupt. When the fast oscillator was off during standby, the CPU clock stays gated for a programmable settling count before it resumes. All enable and status changes wait for a cycle in which `gate_ok` reports that the gated clocks are low, so no runt pulse can appear. A small status record keeps the last standby level entered and the class that ended it.

Top module: `lpclk_ctrl`

## Requirements
- R1: After reset the controller is in run: all five enables are 1, `cpu_div_sel` is 0, `stat_mode` is 0 (none) and `stat_wake` is 0.
- R2: In deep sleep, `en_osc_hs`, `en_cpu`, `en_pclk` and `en_lsp` are 0. `en_osc_ls` equals the value of `cfg_rtc_keep` captured when sleep was entered.
- R3: In halt, `en_cpu` is 0 and `en_osc_ls` is 1. `en_pclk` and `en_osc_hs` both equal the captured `cfg_pclk_halt`, and `en_lsp` equals the captured `cfg_lsp_halt`.
- R4: If `req_sleep` and `req_halt` are both 1 in run, the controller enters deep sleep. Standby is entered on the first edge with `gate_ok`=1 after a request is seen.
- R5: In standby the classes accepted for wakeup are: port always; real-time clock when `en_osc_ls`=1; slow peripherals when `en_lsp`=1; peripheral bus when `en_pclk`=1.
- R6: An interrupt of a class that is not accepted leaves every output unchanged, and the controller stays in standby.
- R7: Waking from halt with `en_pclk`=1 restores run at the wake edge. Any other wakeup keeps `en_cpu` at 0 (with `en_osc_hs` and `en_osc_ls` at 1 and `en_pclk` at 0) for `cfg_stab_cnt`+1 cycles when `gate_ok` stays 1.
- R8: The enables, `cpu_div_sel` and the status fields change only at edges where `gate_ok` was 1.
- R9: In run, `cpu_div_sel` takes `cfg_gear_low` (1 = low gear) at every gated edge. It holds through standby and settling, so the CPU resumes with its previous divider.
- R10: At standby entry, `stat_mode` becomes 1 for sleep or 2 for halt. At wakeup, `stat_wake` becomes the accepted class with the lowest code, with the codes port=0, real-time clock=1, slow peripherals=2, peripheral bus=3.
- R11: `en_cpu` and `en_pclk` are never 1 while `en_osc_hs` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| gate_ok | input | 1 | Gated clocks are low this cycle; updates allowed |
| req_sleep | input | 1 | Deep-sleep request |
| req_halt | input | 1 | Halt request |
| cfg_rtc_keep | input | 1 | Keep slow oscillator for the real-time clock in sleep |
| cfg_pclk_halt | input | 1 | Keep peripheral bus clock (and fast oscillator) in halt |
| cfg_lsp_halt | input | 1 | Keep slow-peripheral clock in halt |
| cfg_gear_low | input | 1 | Low-gear CPU divider select |
| cfg_stab_cnt | input | STAB_W | Fast oscillator settling count |
| irq_port | input | 1 | I/O port interrupt |
| irq_rtc | input | 1 | Real-time clock interrupt |
| irq_lsp | input | 1 | Slow-peripheral interrupt |
| irq_pclk | input | 1 | Peripheral-bus interrupt |
| en_osc_hs | output | 1 | Fast oscillator enable |
| en_osc_ls | output | 1 | Slow oscillator enable |
| en_cpu | output | 1 | CPU clock enable |
| en_pclk | output | 1 | Peripheral bus clock enable |
| en_lsp | output | 1 | Slow-peripheral clock enable |
| cpu_div_sel | output | 1 | CPU divider select (1 = low gear) |
| stat_mode | output | 2 | Last standby entered: 0 none, 1 sleep, 2 halt |
| stat_wake | output | 2 | Class that ended the last standby |

## Verification
Every output comes from registers that update at the same edge that samples the request, interrupt or `gate_ok`. A stimulus applied before edge k therefore shows on the outputs just after edge k. The only exception is the settling window, which ends `cfg_stab_cnt`+1 edges after the wake edge. The bench drives inputs on the falling edge and advances a reference model one step at each rising edge. It compares every output at the next falling edge, which is the first point where the result of that rising edge is due. Directed checks count the cycles of the settling window and the cycles with `gate_ok` low.

// File: rtl/lpclk_pkg.sv
package lpclk_pkg;
   typedef enum logic [1:0] {
      ST_RUN   = 2'd0,
      ST_SLEEP = 2'd1,
      ST_HALT  = 2'd2,
      ST_STAB  = 2'd3
   } lpc_state_t;

   typedef struct packed {
      logic osc_hs;
      logic osc_ls;
      logic cpu;
      logic pclk;
      logic lsp;
   } lpc_en_t;

   localparam int unsigned NUM_WAKE = 4;
   localparam logic [1:0] MODE_NONE  = 2'd0;
   localparam logic [1:0] MODE_SLEEP = 2'd1;
   localparam logic [1:0] MODE_HALT  = 2'd2;
endpackage

// File: rtl/lpclk_wake_sel.sv
module lpclk_wake_sel #(
   parameter int unsigned NCLS = 4,
   localparam int unsigned CW = (NCLS > 1) ? $clog2(NCLS) : 1
) (
   input  logic [NCLS-1:0] irq,
   input  logic [NCLS-1:0] accept,
   output logic            hit,
   output logic [CW-1:0]   cls
);
   logic [NCLS-1:0] masked;

   for (genvar g = 0; g < NCLS; g++) begin : g_mask
      assign masked[g] = irq[g] & accept[g];
   end

   assign hit = |masked;

   // lowest index wins
   always_comb begin
      cls = '0;
      for (int i = NCLS - 1; i >= 0; i--) begin
         if (masked[i]) cls = CW'(i);
      end
   end
endmodule

// File: rtl/lpclk_stab_timer.sv
module lpclk_stab_timer #(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] val,
   output logic         done
);
   logic [W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt <= '0;
      else if (load)       cnt <= val;
      else if (cnt != '0)  cnt <= cnt - 1'b1;
   end

   assign done = (cnt == '0);
endmodule

// File: rtl/lpclk_en_decode.sv
module lpclk_en_decode
   import lpclk_pkg::*;
#(
   parameter bit RTC_IN_SLEEP = 1'b1
) (
   input  lpc_state_t st,
   input  logic       snap_rtc,
   input  logic       snap_pclk,
   input  logic       snap_lsp,
   output lpc_en_t    en
);
   logic sleep_ls;

   if (RTC_IN_SLEEP) begin : g_rtc_keep
      assign sleep_ls = snap_rtc;
   end else begin : g_rtc_off
      assign sleep_ls = 1'b0;
   end

   always_comb begin
      unique case (st)
         ST_RUN:   en = '{osc_hs: 1'b1, osc_ls: 1'b1, cpu: 1'b1, pclk: 1'b1, lsp: 1'b1};
         ST_SLEEP: en = '{osc_hs: 1'b0, osc_ls: sleep_ls, cpu: 1'b0, pclk: 1'b0, lsp: 1'b0};
         ST_HALT:  en = '{osc_hs: snap_pclk, osc_ls: 1'b1, cpu: 1'b0, pclk: snap_pclk, lsp: snap_lsp};
         default:  en = '{osc_hs: 1'b1, osc_ls: 1'b1, cpu: 1'b0, pclk: 1'b0, lsp: 1'b1};
      endcase
   end
endmodule

// File: rtl/lpclk_ctrl.sv
module lpclk_ctrl
   import lpclk_pkg::*;
#(
   parameter int unsigned STAB_W       = 8,
   parameter bit          RTC_IN_SLEEP = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              gate_ok,
   input  logic              req_sleep,
   input  logic              req_halt,
   input  logic              cfg_rtc_keep,
   input  logic              cfg_pclk_halt,
   input  logic              cfg_lsp_halt,
   input  logic              cfg_gear_low,
   input  logic [STAB_W-1:0] cfg_stab_cnt,
   input  logic              irq_port,
   input  logic              irq_rtc,
   input  logic              irq_lsp,
   input  logic              irq_pclk,
   output logic              en_osc_hs,
   output logic              en_osc_ls,
   output logic              en_cpu,
   output logic              en_pclk,
   output logic              en_lsp,
   output logic              cpu_div_sel,
   output logic [1:0]        stat_mode,
   output logic [1:0]        stat_wake
);
   localparam int unsigned CW = $clog2(NUM_WAKE);

   if (STAB_W < 1 || STAB_W > 24) begin : g_bad_stab_w
      $error("lpclk_ctrl: STAB_W out of range 1..24");
   end
   if (CW != 2) begin : g_bad_cls
      $error("lpclk_ctrl: status field needs four wake classes");
   end

   lpc_state_t st, st_nxt;
   lpc_en_t    en;
   logic       snap_rtc, snap_pclk, snap_lsp, gear;
   logic       hit, stab_done, stab_load, wake_take, standby;
   logic [CW-1:0] cls;
   logic [NUM_WAKE-1:0] irq_vec, acc_vec;

   lpclk_en_decode #(.RTC_IN_SLEEP(RTC_IN_SLEEP)) u_dec (
      .st(st), .snap_rtc(snap_rtc), .snap_pclk(snap_pclk), .snap_lsp(snap_lsp), .en(en)
   );

   assign standby = (st == ST_SLEEP) || (st == ST_HALT);
   assign irq_vec = {irq_pclk, irq_lsp, irq_rtc, irq_port};
   assign acc_vec = {en.pclk, en.lsp, en.osc_ls, 1'b1} & {NUM_WAKE{standby}};

   lpclk_wake_sel #(.NCLS(NUM_WAKE)) u_wsel (
      .irq(irq_vec), .accept(acc_vec), .hit(hit), .cls(cls)
   );

   lpclk_stab_timer #(.W(STAB_W)) u_stab (
      .clk(clk), .rst_n(rst_n), .load(stab_load), .val(cfg_stab_cnt), .done(stab_done)
   );

   assign wake_take = standby && gate_ok && hit;

   always_comb begin
      st_nxt    = st;
      stab_load = 1'b0;
      unique case (st)
         ST_RUN: begin
            if (gate_ok && req_sleep)     st_nxt = ST_SLEEP;
            else if (gate_ok && req_halt) st_nxt = ST_HALT;
         end
         ST_SLEEP: begin
            if (wake_take) begin
               st_nxt    = ST_STAB;
               stab_load = 1'b1;
            end
         end
         ST_HALT: begin
            if (wake_take) begin
               if (snap_pclk) st_nxt = ST_RUN;
               else begin
                  st_nxt    = ST_STAB;
                  stab_load = 1'b1;
               end
            end
         end
         default: begin
            if (gate_ok && stab_done) st_nxt = ST_RUN;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= ST_RUN;
         snap_rtc  <= 1'b0;
         snap_pclk <= 1'b0;
         snap_lsp  <= 1'b0;
         gear      <= 1'b0;
         stat_mode <= MODE_NONE;
         stat_wake <= '0;
      end else begin
         st <= st_nxt;
         if (st == ST_RUN && gate_ok) begin
            gear <= cfg_gear_low;
            if (req_sleep) begin
               snap_rtc  <= cfg_rtc_keep;
               stat_mode <= MODE_SLEEP;
            end else if (req_halt) begin
               snap_pclk <= cfg_pclk_halt;
               snap_lsp  <= cfg_lsp_halt;
               stat_mode <= MODE_HALT;
            end
         end
         if (wake_take) stat_wake <= cls;
      end
   end

   assign en_osc_hs   = en.osc_hs;
   assign en_osc_ls   = en.osc_ls;
   assign en_cpu      = en.cpu;
   assign en_pclk     = en.pclk;
   assign en_lsp      = en.lsp;
   assign cpu_div_sel = gear;
endmodule

// File: rtl/lpclk_ctrl_chk.sv
module lpclk_ctrl_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       gate_ok,
   input logic       irq_port,
   input logic       irq_rtc,
   input logic       irq_lsp,
   input logic       irq_pclk,
   input logic       en_osc_hs,
   input logic       en_osc_ls,
   input logic       en_cpu,
   input logic       en_pclk,
   input logic       en_lsp,
   input logic       cpu_div_sel,
   input logic [1:0] stat_mode,
   input logic [1:0] stat_wake
);
   logic accepted;
   assign accepted = irq_port | (irq_rtc & en_osc_ls) | (irq_lsp & en_lsp) | (irq_pclk & en_pclk);

   p_gate_phase_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !gate_ok |=> $stable({en_osc_hs, en_osc_ls, en_cpu, en_pclk, en_lsp, cpu_div_sel, stat_mode, stat_wake}));

   p_cpu_needs_hs_r11: assert property (@(posedge clk) disable iff (!rst_n)
      en_cpu |-> en_osc_hs);

   p_pclk_needs_hs_r11: assert property (@(posedge clk) disable iff (!rst_n)
      en_pclk |-> en_osc_hs);

   p_ignored_wake_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !accepted |=> $stable(stat_wake));

   p_div_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !en_cpu |=> $stable(cpu_div_sel));

   p_sleep_dark_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!en_osc_hs && !en_osc_ls) |-> (!en_lsp && !en_pclk));
endmodule

bind lpclk_ctrl lpclk_ctrl_chk u_chk (.*);

// File: tb/lpclk_ctrl_tb_top.sv
module lpclk_ctrl_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int SW = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic gate_ok = 1'b1, req_sleep = 1'b0, req_halt = 1'b0;
   logic cfg_rtc_keep = 1'b0, cfg_pclk_halt = 1'b0, cfg_lsp_halt = 1'b0, cfg_gear_low = 1'b0;
   logic [SW-1:0] cfg_stab_cnt = '0;
   logic irq_port = 1'b0, irq_rtc = 1'b0, irq_lsp = 1'b0, irq_pclk = 1'b0;
   logic en_osc_hs, en_osc_ls, en_cpu, en_pclk, en_lsp, cpu_div_sel;
   logic [1:0] stat_mode, stat_wake;

   int n_chk = 0, n_fail = 0;
   bit finished = 0;

   // reference model: 0 run, 1 sleep, 2 halt, 3 settling
   int m_st = 0, m_cnt = 0;
   logic m_rtc = 0, m_pclk = 0, m_lsp = 0, m_gear = 0;
   logic [1:0] m_mode = 0, m_wake = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   lpclk_ctrl #(.STAB_W(SW), .RTC_IN_SLEEP(1'b1)) dut_i (.*);

   function automatic logic [4:0] exp_en(int s);
      case (s)
         0: return 5'b11111;
         1: return {1'b0, m_rtc, 3'b000};
         2: return {m_pclk, 1'b1, 1'b0, m_pclk, m_lsp};
         default: return 5'b11001;
      endcase
   endfunction

   function automatic string st_tag(int s);
      case (s)
         0: return "R1";
         1: return "R2";
         2: return "R3";
         default: return "R7";
      endcase
   endfunction

   task automatic chk(string tag, string what, logic [7:0] act, logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
      end
   endtask

   task automatic model_step();
      logic [4:0] e;
      logic [3:0] acc;
      e = exp_en(m_st);
      acc = {irq_pclk & e[1], irq_lsp & e[0], irq_rtc & e[3], irq_port};
      case (m_st)
         0: if (gate_ok) begin
               m_gear = cfg_gear_low;
               if (req_sleep) begin m_st = 1; m_rtc = cfg_rtc_keep; m_mode = 2'd1; end
               else if (req_halt) begin m_st = 2; m_pclk = cfg_pclk_halt; m_lsp = cfg_lsp_halt; m_mode = 2'd2; end
            end
         1, 2: if (gate_ok && acc != 0) begin
               m_wake = acc[0] ? 2'd0 : acc[1] ? 2'd1 : acc[2] ? 2'd2 : 2'd3;
               if (m_st == 2 && m_pclk) m_st = 0;
               else begin m_st = 3; m_cnt = int'(cfg_stab_cnt); end
            end
         default: if (m_cnt != 0) m_cnt--; else if (gate_ok) m_st = 0;
      endcase
   endtask

   task automatic compare();
      logic [4:0] e;
      string t;
      e = exp_en(m_st);
      t = st_tag(m_st);
      chk(t, "enables", {3'b0, en_osc_hs, en_osc_ls, en_cpu, en_pclk, en_lsp}, {3'b0, e});
      chk("R9", "cpu_div_sel", {7'b0, cpu_div_sel}, {7'b0, m_gear});
      chk("R10", "stat_mode", {6'b0, stat_mode}, {6'b0, m_mode});
      chk("R10", "stat_wake", {6'b0, stat_wake}, {6'b0, m_wake});
      chk("R11", "hs osc under cpu/pclk", {7'b0, (en_cpu | en_pclk) & ~en_osc_hs}, 8'd0);
   endtask

   // one clock: model follows the rising edge, outputs compared at the falling edge
   task automatic cyc();
      @(posedge clk);
      #1;
      model_step();
      @(negedge clk);
      compare();
   endtask

   task automatic clear_in();
      req_sleep = 0; req_halt = 0;
      irq_port = 0; irq_rtc = 0; irq_lsp = 0; irq_pclk = 0;
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog actual=running expected=done");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin : main
      int zc;
      void'($urandom(32'd4711));
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      compare(); // R1 reset state

      // R4: both requests, sleep wins; rtc domain off
      cfg_rtc_keep = 0; cfg_stab_cnt = 8'd5;
      req_sleep = 1; req_halt = 1;
      cyc();
      chk("R4", "stat_mode after both requests", {6'b0, stat_mode}, 8'd1);
      chk("R4", "en_osc_hs in sleep", {7'b0, en_osc_hs}, 8'd0);
      clear_in();

      // R6: non-accepted classes ignored in dark sleep
      irq_rtc = 1; irq_lsp = 1; irq_pclk = 1;
      repeat (3) cyc();
      chk("R6", "en_cpu stays off", {7'b0, en_cpu}, 8'd0);
      chk("R6", "en_osc_hs stays off", {7'b0, en_osc_hs}, 8'd0);
      clear_in();

      // R5: port always accepted; R7 settling length
      irq_port = 1;
      cyc();
      clear_in();
      chk("R5", "settling started by port", {7'b0, en_osc_hs}, 8'd1);
      chk("R10", "wake class port", {6'b0, stat_wake}, 8'd0);
      zc = 0;
      while (!en_cpu && zc < 60) begin zc++; cyc(); end
      chk("R7", "cycles with cpu gated after wake", 8'(zc), 8'd6);

      // R3/R7: halt with peripheral bus running, direct resume
      cfg_pclk_halt = 1; cfg_lsp_halt = 0; cfg_gear_low = 1;
      req_halt = 1;
      cyc();
      clear_in();
      chk("R3", "en_pclk kept in halt", {7'b0, en_pclk}, 8'd1);
      chk("R9", "low gear captured", {7'b0, cpu_div_sel}, 8'd1);
      cfg_gear_low = 0;
      irq_lsp = 1;
      cyc();
      chk("R6", "slow-peripheral irq ignored", {7'b0, en_cpu}, 8'd0);
      chk("R9", "gear held in halt", {7'b0, cpu_div_sel}, 8'd1);
      irq_lsp = 0; irq_pclk = 1; irq_rtc = 1;
      cyc();
      clear_in();
      chk("R7", "direct resume from halt", {7'b0, en_cpu}, 8'd1);
      chk("R10", "rtc wins over pclk", {6'b0, stat_wake}, 8'd1);

      // R8: no change while gate_ok is low
      gate_ok = 0; req_sleep = 1;
      repeat (3) cyc();
      chk("R8", "sleep held off by gate_ok", {7'b0, en_cpu}, 8'd1);
      gate_ok = 1;
      cyc();
      chk("R8", "sleep after gate_ok", {7'b0, en_cpu}, 8'd0);
      clear_in();
      irq_port = 1;
      cyc();
      clear_in();

      // random phase
      for (int k = 0; k < 4000; k++) begin
         gate_ok   = ($urandom % 10) < 7;
         req_sleep = ($urandom % 16) == 0;
         req_halt  = ($urandom % 8) == 0;
         irq_port  = ($urandom % 20) == 0;
         irq_rtc   = ($urandom % 8) == 0;
         irq_lsp   = ($urandom % 8) == 0;
         irq_pclk  = ($urandom % 8) == 0;
         if (($urandom % 30) == 0) begin
            cfg_rtc_keep  = 1'($urandom);
            cfg_pclk_halt = 1'($urandom);
            cfg_lsp_halt  = 1'($urandom);
            cfg_gear_low  = 1'($urandom);
            cfg_stab_cnt  = SW'($urandom % 16);
         end
         cyc();
      end

      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule